// File: doc/BRIEF.md
# Panel Power-Up Sequencer

This block takes a quarter-VGA display panel from its reset condition to an active, lit display. On a start pulse it walks a fixed list of register writes, handing each one to a separate register-write framer through a request/ready handshake. It holds the bus idle for fixed millisecond pauses between the power phases. The pauses are timed by a prescaler, which is set by a parameter giving the number of clock cycles per millisecond.

When the framer reports an error, the sequencer leaves the normal path and plays an unwind list that returns the panel to a safe, powered-down state. The point of failure decides where the unwind list is entered. A failure in the first power writes needs only one write. A failure later in power-up first clears the second power register. A failure while the display is being switched on first restores the two registers that this step changed. Errors in the block of instruction settings are collected and acted on only once the whole block has been sent.

Top module: `panel_pwrup_seq`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done`, `fail` and `wr_req` are all low.
- R2: A `start` pulse seen while idle raises `busy` on the next cycle. The first write requested is address 0x09 with data 0x0000.
- R3: With no errors, exactly 24 writes are issued in this order (address=data): 09=0000, 09=4000, 0A=2000, 09=4055, 01=409D, 02=0204, 03=0100, 04=3000, 05=4003, 06=000A, 07=0021, 08=0C00, 10=0103, 11=0301, 12=1F0F, 13=1F0F, 14=0707, 15=0307, 16=0707, 17=0000, 18=0004, 19=0000, 09=4A55, 05=5003.
- R4: After the write 09=0000 the bus stays idle for 15 ms, after 09=4055 for 55 ms, and after the write to 0x19 for 20 ms. Each pause is ms × CYCLES_PER_MS cycles plus one decision cycle. All other writes follow one another with no pause.
- R5: `wr_req` stays high, with `wr_addr`/`wr_data` stable, until `wr_ready` is high. A write completes in the cycle where both are high, and `wr_err` is sampled in that cycle.
- R6: After the last write (05=5003) completes without error, `busy` falls and `done` rises in the same cycle.
- R7: An error on write 09=0000 or on write 09=4000 is followed immediately by the single write 09=4000, and then `fail`.
- R8: An error on write 0A=2000 or on write 09=4055 is followed immediately by 0A=0000, then a 1 ms pause, then 09=4000, and then `fail`.
- R9: An error on any instruction-setting write (addresses 0x01–0x08 and 0x10–0x19) does not stop that group. All settings are still issued, then the R8 unwind follows with no 20 ms pause.
- R10: An error on either display-on write (09=4A55, 05=5003) lets both be issued, then 09=4055, 05=4003, 0A=0000, a 1 ms pause, 09=4000, and then `fail`.
- R11: `start` has no effect while `busy` is high. Errors reported on unwind writes are ignored, and the unwind list runs to its end.
- R12: `done` and `fail` are never high together. Each holds until the next accepted `start`, which clears both on the cycle `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a power-up run when idle |
| wr_req | output | 1 | Register write requested from the framer |
| wr_addr | output | 7 | Panel register address of the pending write |
| wr_data | output | 16 | Value of the pending write |
| wr_ready | input | 1 | Framer accepts and completes the pending write this cycle |
| wr_err | input | 1 | Framer reports that the write completing this cycle failed |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last run finished with the display on |
| fail | output | 1 | Last run ended through the unwind path |

## Verification
The properties assume a framer that raises `wr_ready` only while `wr_req` is high, and that gives `wr_err` meaning only in that same cycle. They also assume reset is held for at least one clock before the first check. The bench framer model drives both signals on the falling edge, only in reply to an active request. It answers after a latency of zero to two cycles, which rotates from write to write, and it drops both signals after each acceptance. Error injection uses a mask over write ordinals, so faults land on chosen points of the normal and unwind lists.

// File: rtl/pwrseq_pkg.sv
// Shared types and constants for the panel power-up sequencer.
// Assumes a 7-bit register address and 16-bit register data on the framer side.
package pwrseq_pkg;

    localparam int unsigned ADDR_W = 7;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned IDX_W  = 5;

    // Step positions the control logic depends on
    localparam logic [IDX_W-1:0] IDX_UNW_DISP  = 5'd24;
    localparam logic [IDX_W-1:0] IDX_UNW_FULL  = 5'd26;
    localparam logic [IDX_W-1:0] IDX_UNW_SHORT = 5'd27;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_PWR1  = 7'h09;
    localparam logic [ADDR_W-1:0] A_PWR2  = 7'h0A;
    localparam logic [ADDR_W-1:0] A_GATE2 = 7'h05;
    localparam logic [ADDR_W-1:0] A_GAMMA = 7'h10;

    // Field values
    localparam logic [DATA_W-1:0] P1_VCOM_OFF = 16'h4000;
    localparam logic [DATA_W-1:0] P1_CURRENTS = 16'h0055;
    localparam logic [DATA_W-1:0] P1_VCOM_OUT = 16'h0800;
    localparam logic [DATA_W-1:0] P1_PWR_ON   = 16'h0200;
    localparam logic [DATA_W-1:0] P2_VCOML_EN = 16'h2000;
    localparam logic [DATA_W-1:0] G2_BASE     = 16'h4003;
    localparam logic [DATA_W-1:0] G2_DISP_ON  = 16'h1000;

    typedef enum logic [2:0] {DLY_NONE, DLY_RESET, DLY_SETTLE, DLY_FRAMES, DLY_UNWIND} dly_e;
    typedef enum logic [1:0] {CHK_NONE, CHK_NOW, CHK_GROUP} chk_e;
    typedef enum logic [1:0] {RB_NONE, RB_SHORT, RB_FULL, RB_DISP} rb_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        dly_e              dly;
        chk_e              chk;
        rb_e               rb;
        logic              last;
    } step_t;

endpackage

// File: rtl/pwrseq_step_rom.sv
// Combinational step table: maps a step index to the write, the pause after it,
// how its error is judged and where a failure rejoins the unwind list.
// Assumes indices 0..23 form the power-up list and 24..27 the unwind list.
module pwrseq_step_rom
    import pwrseq_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output step_t            step
);

    // Gamma curve values, indexed from the first gamma register
    function automatic logic [DATA_W-1:0] gamma_val(input logic [3:0] g);
        case (g)
            4'd0:    return 16'h0103;
            4'd1:    return 16'h0301;
            4'd2:    return 16'h1F0F;
            4'd3:    return 16'h1F0F;
            4'd4:    return 16'h0707;
            4'd5:    return 16'h0307;
            4'd6:    return 16'h0707;
            4'd8:    return 16'h0004;
            default: return 16'h0000;
        endcase
    endfunction

    // Decode one table row
    always_comb begin
        logic [IDX_W-1:0] gi;
        gi   = idx - 5'd12;
        step = '{addr: A_PWR1, data: '0, dly: DLY_NONE, chk: CHK_NONE, rb: RB_FULL, last: 1'b0};
        case (idx)
            5'd0:  begin step.data = '0;                       step.dly = DLY_RESET;  step.chk = CHK_NOW; step.rb = RB_SHORT; end
            5'd1:  begin step.data = P1_VCOM_OFF;              step.chk = CHK_NOW;    step.rb = RB_SHORT; end
            5'd2:  begin step.addr = A_PWR2; step.data = P2_VCOML_EN; step.chk = CHK_NOW; end
            5'd3:  begin step.data = P1_VCOM_OFF | P1_CURRENTS; step.dly = DLY_SETTLE; step.chk = CHK_NOW; end
            5'd4:  begin step.addr = 7'h01; step.data = 16'h409D; end
            5'd5:  begin step.addr = 7'h02; step.data = 16'h0204; end
            5'd6:  begin step.addr = 7'h03; step.data = 16'h0100; end
            5'd7:  begin step.addr = 7'h04; step.data = 16'h3000; end
            5'd8:  begin step.addr = A_GATE2; step.data = G2_BASE; end
            5'd9:  begin step.addr = 7'h06; step.data = 16'h000A; end
            5'd10: begin step.addr = 7'h07; step.data = 16'h0021; end
            5'd11: begin step.addr = 7'h08; step.data = 16'h0C00; end
            5'd22: begin step.data = P1_VCOM_OFF | P1_VCOM_OUT | P1_PWR_ON | P1_CURRENTS; step.rb = RB_DISP; end
            5'd23: begin step.addr = A_GATE2; step.data = G2_BASE | G2_DISP_ON; step.chk = CHK_GROUP; step.rb = RB_DISP; step.last = 1'b1; end
            5'd24: begin step.data = P1_VCOM_OFF | P1_CURRENTS; step.rb = RB_NONE; end
            5'd25: begin step.addr = A_GATE2; step.data = G2_BASE; step.rb = RB_NONE; end
            5'd26: begin step.addr = A_PWR2; step.data = '0; step.dly = DLY_UNWIND; step.rb = RB_NONE; end
            5'd27: begin step.data = P1_VCOM_OFF; step.rb = RB_NONE; step.last = 1'b1; end
            default: begin
                step.addr = A_GAMMA + ADDR_W'(gi);
                step.data = gamma_val(gi[3:0]);
                if (idx == 5'd21) begin
                    step.dly = DLY_FRAMES;
                    step.chk = CHK_GROUP;
                end
            end
        endcase
    end

endmodule

// File: rtl/pwrseq_ms_timer.sv
// Millisecond pause timer: a prescaler of CYCLES_PER_MS cycles drives a
// down-counter of milliseconds. Assumes load is only pulsed while expired is high.
module pwrseq_ms_timer #(
    parameter int unsigned CYCLES_PER_MS = 50000,
    parameter int unsigned MS_W          = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            expired
);

    localparam int unsigned     PRE_W    = $clog2(CYCLES_PER_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_MS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;

    // Count cycles into milliseconds and milliseconds down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (load) begin
            pre_q <= '0;
            ms_q  <= load_ms;
        end else if (ms_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                ms_q  <= ms_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired = (ms_q == '0);

endmodule

// File: rtl/panel_pwrup_seq.sv
// Panel power-up sequencer: walks the step table, hands each write to the
// framer, pauses where the table says so, and on an error jumps into the
// unwind list at the entry chosen by the failing step.
// Assumes wr_ready/wr_err are meaningful only while wr_req is high.
module panel_pwrup_seq
    import pwrseq_pkg::*;
#(
    parameter int unsigned CYCLES_PER_MS = 50000,
    parameter int unsigned MS_RESET      = 15,
    parameter int unsigned MS_SETTLE     = 55,
    parameter int unsigned MS_FRAMES     = 20,
    parameter int unsigned MS_UNWIND     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    input  logic              wr_err,
    output logic              busy,
    output logic              done,
    output logic              fail
);

    localparam int unsigned MAX_AB = (MS_RESET > MS_SETTLE) ? MS_RESET : MS_SETTLE;
    localparam int unsigned MAX_CD = (MS_FRAMES > MS_UNWIND) ? MS_FRAMES : MS_UNWIND;
    localparam int unsigned MS_MAX = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned MS_W   = $clog2(MS_MAX + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;

    state_e           state_q;
    logic [IDX_W-1:0] idx_q;
    logic             unwind_q;
    logic             acc_err_q;
    logic             done_q;
    logic             fail_q;

    step_t            cur;
    logic             accept;
    logic             grp_err;
    logic             bad;
    logic [IDX_W-1:0] rb_idx;
    logic             tmr_load;
    logic [MS_W-1:0]  tmr_ms;
    logic             tmr_expired;

    pwrseq_step_rom u_rom (
        .idx  (idx_q),
        .step (cur)
    );

    pwrseq_ms_timer #(
        .CYCLES_PER_MS (CYCLES_PER_MS),
        .MS_W          (MS_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_ms (tmr_ms),
        .expired (tmr_expired)
    );

    // Judge the completing write and pick the unwind entry
    always_comb begin
        accept  = (state_q == ST_ISSUE) && wr_ready;
        grp_err = acc_err_q | wr_err;
        bad     = !unwind_q && (((cur.chk == CHK_NOW) && wr_err) ||
                                ((cur.chk == CHK_GROUP) && grp_err));
        case (cur.rb)
            RB_DISP:  rb_idx = IDX_UNW_DISP;
            RB_FULL:  rb_idx = IDX_UNW_FULL;
            default:  rb_idx = IDX_UNW_SHORT;
        endcase
    end

    // Select the pause length and start the timer on a clean completion
    always_comb begin
        case (cur.dly)
            DLY_RESET:  tmr_ms = MS_W'(MS_RESET);
            DLY_SETTLE: tmr_ms = MS_W'(MS_SETTLE);
            DLY_FRAMES: tmr_ms = MS_W'(MS_FRAMES);
            DLY_UNWIND: tmr_ms = MS_W'(MS_UNWIND);
            default:    tmr_ms = '0;
        endcase
        tmr_load = accept && !bad && (cur.dly != DLY_NONE);
    end

    // Sequence control: idle, issue a write, pause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            unwind_q  <= 1'b0;
            acc_err_q <= 1'b0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q   <= ST_ISSUE;
                        idx_q     <= '0;
                        unwind_q  <= 1'b0;
                        acc_err_q <= 1'b0;
                        done_q    <= 1'b0;
                        fail_q    <= 1'b0;
                    end
                end
                ST_ISSUE: begin
                    if (wr_ready) begin
                        if (bad) begin
                            idx_q     <= rb_idx;
                            unwind_q  <= 1'b1;
                            acc_err_q <= 1'b0;
                        end else if (cur.last) begin
                            state_q <= ST_IDLE;
                            done_q  <= !unwind_q;
                            fail_q  <= unwind_q;
                        end else begin
                            idx_q     <= idx_q + 5'd1;
                            acc_err_q <= (cur.chk == CHK_NONE) && !unwind_q && grp_err;
                            state_q   <= (cur.dly != DLY_NONE) ? ST_WAIT : ST_ISSUE;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tmr_expired) state_q <= ST_ISSUE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign wr_req  = (state_q == ST_ISSUE);
    assign wr_addr = cur.addr;
    assign wr_data = cur.data;
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign fail    = fail_q;

endmodule

// File: rtl/pwrseq_chk.sv
// Protocol and status checker for panel_pwrup_seq, attached by bind.
// Assumes reset is held low for at least one clock at power-up.
module pwrseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        wr_req,
    input logic [6:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic        wr_ready,
    input logic        busy,
    input logic        done,
    input logic        fail
);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ready) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_status_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    assert_first_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && wr_req && wr_addr == 7'h09 && wr_data == 16'h0000));

    assert_end_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done != fail));

    assert_end_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) || $rose(fail)) |-> $past(wr_req && wr_ready));

endmodule

bind panel_pwrup_seq pwrseq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wr_req   (wr_req),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .busy     (busy),
    .done     (done),
    .fail     (fail)
);

// File: tb/sim_panel_pwrup_seq.sv
// Scoreboard bench: scenario tasks queue the expected writes, a framer model
// on the falling edge answers requests and compares each write and pause.
module sim_panel_pwrup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wr_ready = 1'b0;
    logic        wr_err = 1'b0;
    logic        wr_req;
    logic [6:0]  wr_addr;
    logic [15:0] wr_data;
    logic        busy, done, fail;

    panel_pwrup_seq #(.CYCLES_PER_MS(CPM)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .wr_err(wr_err),
        .busy(busy), .done(done), .fail(fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [6:0]  a;
        logic [15:0] d;
        int          gap;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [63:0] err_mask = '0;
    int          ord = 0;
    int          lat = 0;
    int          cyc = 0;
    int          acc_cyc = 0;
    bit          gap_pending = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected table taken from the requirement text
    function automatic logic [6:0] exp_addr(input int i);
        case (i)
            0, 1, 3, 22, 24, 27: return 7'h09;
            2, 26:               return 7'h0A;
            4: return 7'h01;  5: return 7'h02;  6: return 7'h03;  7: return 7'h04;
            8, 23, 25:           return 7'h05;
            9: return 7'h06;  10: return 7'h07; 11: return 7'h08;
            default:             return 7'(7'h10 + i - 12);
        endcase
    endfunction

    function automatic logic [15:0] exp_data(input int i);
        case (i)
            0: return 16'h0000;  1: return 16'h4000;  2: return 16'h2000;  3: return 16'h4055;
            4: return 16'h409D;  5: return 16'h0204;  6: return 16'h0100;  7: return 16'h3000;
            8: return 16'h4003;  9: return 16'h000A;  10: return 16'h0021; 11: return 16'h0C00;
            12: return 16'h0103; 13: return 16'h0301; 14: return 16'h1F0F; 15: return 16'h1F0F;
            16: return 16'h0707; 17: return 16'h0307; 18: return 16'h0707; 19: return 16'h0000;
            20: return 16'h0004; 21: return 16'h0000; 22: return 16'h4A55; 23: return 16'h5003;
            24: return 16'h4055; 25: return 16'h4003; 26: return 16'h0000;
            default: return 16'h4000;
        endcase
    endfunction

    function automatic int ms_gap(input int ms);
        return ms * CPM + 2;
    endfunction

    // Falling edges from one accepted write to the next request (R4)
    function automatic int ok_gap(input int i);
        if (i == 0)  return -1;
        if (i == 1)  return ms_gap(15);
        if (i == 4)  return ms_gap(55);
        if (i == 22) return ms_gap(20);
        return 2;
    endfunction

    task automatic push(input int i, input int gap, input string tag);
        exp_t e;
        e.a = exp_addr(i); e.d = exp_data(i); e.gap = gap; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic push_prefix(input int last);
        for (int i = 0; i <= last; i++) push(i, ok_gap(i), "R3 R5");
    endtask

    // Framer model and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            wr_ready = 1'b0;
            wr_err   = 1'b0;
        end else if (wr_ready) begin
            wr_ready = 1'b0;
            wr_err   = 1'b0;
            lat      = 0;
        end else if (wr_req) begin
            if (gap_pending) begin
                gap_pending = 0;
                if (sb.size() != 0 && sb[0].gap >= 0)
                    check((cyc - acc_cyc) == sb[0].gap, {"R4 ", sb[0].tag}, "pause before write",
                          cyc - acc_cyc, sb[0].gap);
            end
            if (lat < (ord % 3)) begin
                lat++;
            end else begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3", "unexpected write", {wr_addr, wr_data}, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(wr_addr == e.a && wr_data == e.d, e.tag, "write addr/data",
                          {wr_addr, wr_data}, {e.a, e.d});
                end
                wr_ready    = 1'b1;
                wr_err      = err_mask[ord];
                ord++;
                acc_cyc     = cyc;
                gap_pending = 1;
            end
        end
    end

    // One run: start, optional second start while busy, wait for the end
    task automatic run(input logic [63:0] mask, input string req, input bit exp_fail, input bit poke);
        int guard;
        err_mask = mask; ord = 0; gap_pending = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
        check(done == 1'b0 && fail == 1'b0, "R12", "status cleared on start", {done, fail}, 0);
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            check(busy == 1'b1, "R11", "busy kept across start", busy, 1);
        end
        guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(sb.size() == 0, req, "writes left unissued", sb.size(), 0);
        check(done == !exp_fail, req, "done at end", done, !exp_fail);
        check(fail == exp_fail, req, "fail at end", fail, exp_fail);
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && done == !exp_fail && fail == exp_fail, "R12", "status held",
              {busy, done, fail}, {1'b0, !exp_fail, exp_fail});
        sb.delete();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(busy == 0 && done == 0 && fail == 0 && wr_req == 0, "R1", "outputs in reset",
              {busy, done, fail, wr_req}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && done == 0 && fail == 0 && wr_req == 0, "R1", "outputs after reset",
              {busy, done, fail, wr_req}, 0);

        // R3 R4 R6 R11: clean run with a stray start mid-run
        push_prefix(23);
        run('0, "R6", 1'b0, 1'b1);

        // R7: error on each of the first two power writes
        for (int e = 0; e <= 1; e++) begin
            push_prefix(e);
            push(27, 2, "R7");
            run(64'd1 << e, "R7", 1'b1, 1'b0);
        end

        // R8: error on the second power register write and on the current write
        for (int e = 2; e <= 3; e++) begin
            push_prefix(e);
            push(26, 2, "R8");
            push(27, ms_gap(1), "R8");
            run(64'd1 << e, "R8", 1'b1, 1'b0);
        end

        // R9: error early in the settings group, group still sent in full
        push_prefix(21);
        push(26, 2, "R9");
        push(27, ms_gap(1), "R9");
        run(64'd1 << 5, "R9", 1'b1, 1'b0);

        // R10 R11: error on first display-on write, plus an error on an unwind write
        push_prefix(23);
        push(24, 2, "R10"); push(25, 2, "R10"); push(26, 2, "R11");
        push(27, ms_gap(1), "R10");
        run((64'd1 << 22) | (64'd1 << 24), "R10", 1'b1, 1'b0);

        // R10: error on the last display-on write
        push_prefix(23);
        push(24, 2, "R10"); push(25, 2, "R10"); push(26, 2, "R10");
        push(27, ms_gap(1), "R10");
        run(64'd1 << 23, "R10", 1'b1, 1'b0);

        // R12: clean run after a failure clears fail and sets done
        push_prefix(23);
        run('0, "R12", 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual %0d expected 0", 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule